// File: doc/BRIEF.md
# Bidirectional Logarithmic Variable Shifter

This block moves the bits of an 8-bit two's-complement word toward the MSB or toward the LSB by any distance from zero to seven places. It has no clock and no state, so the shifted word follows the inputs within the same cycle. The structure is a cascade of three stages with weights of one, two and four places. Each stage is a three-way multiplexer with a one-hot select. One leg passes the word through unchanged, one takes it moved left by the stage weight, and one takes it moved right by the stage weight. Bit *i* of the distance input drives stage *i*.

A two-bit fill mode sets what enters the vacated positions. Logical mode fills with zeros. Arithmetic mode copies the sign bit into the positions freed by a right move. Wrap mode turns the cascade into a barrel rotator that loses no bits. The select vector of every stage is also brought out at the ports, so the surrounding logic can see which leg each stage took.

Top module: `shift_net`

## Requirements
- R1: When `amount` is 0, `dout` equals `din` for every `dir` and every `mode`.
- R2: With `dir` = 1 and `mode` other than 2'b10, `dout` equals `din` moved toward the MSB by `amount` places, with zeros in the vacated low bits.
- R3: With `dir` = 0 and `mode` = 2'b00, `dout` equals `din` moved toward the LSB by `amount` places, with zeros in the vacated high bits (unsigned divide by 2^amount).
- R4: With `dir` = 0 and `mode` = 2'b01, `dout` equals `din` moved toward the LSB by `amount` places, with copies of `din[7]` in the vacated high bits (signed divide by 2^amount, rounding toward minus infinity).
- R5: With `mode` = 2'b10, `dout` is `din` rotated by `amount` places: toward the MSB when `dir` = 1 and toward the LSB when `dir` = 0. Bits leaving one end enter at the other end, so the number of set bits stays the same.
- R6: In rotate mode, a distance of 4 gives the same `dout` for both values of `dir`.
- R7: `mode` = 2'b11 behaves exactly like `mode` = 2'b00.
- R8: `stage_sel[3g+2:3g]` is the select of stage g, which has weight 2^g. Bit 3g+2 selects the left leg, bit 3g+1 the pass leg, and bit 3g the right leg. Exactly one of the three bits is set. The pass bit is set when `amount[g]` = 0. The left bit is set when `amount[g]` = 1 and `dir` = 1. The right bit is set when `amount[g]` = 1 and `dir` = 0.
- R9: The block is purely combinational. `dout` and `stage_sel` match the current inputs in the same clock period in which the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 8 | Word to be shifted |
| dir | input | 1 | 1 = toward MSB, 0 = toward LSB |
| amount | input | 3 | Shift distance, 0 to 7 |
| mode | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 same as logical |
| dout | output | 8 | Shifted word |
| stage_sel | output | 9 | One-hot selects of the three stages, 3 bits per stage |

## Verification
Every result of this block is due in the same cycle as its stimulus, because there is no register anywhere in the path. The bench applies each input set just after a falling edge and samples `dout` and `stage_sel` one nanosecond later, well before the next rising edge. This confirms that nothing waits for a clock edge. It first walks a vector table of hand-computed corner values. It then sweeps every word, distance, direction and mode against a reference model built from the language's own shift operators.

// File: rtl/shift_net_pkg.sv
`timescale 1ns/1ps
package shift_net_pkg;

    localparam int DATA_W = 8;
    localparam int AMT_W  = $clog2(DATA_W);
    localparam int SEL_W  = 3;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'b00,
        FILL_SIGN = 2'b01,
        FILL_WRAP = 2'b10,
        FILL_RSVD = 2'b11
    } fill_mode_e;

    // one-hot three-way select: top = left leg, mid = pass, bot = right leg
    typedef struct packed {
        logic top;
        logic mid;
        logic bot;
    } mux_sel_t;

    function automatic mux_sel_t stage_select(input logic amt_bit, input logic to_msb);
        mux_sel_t s;
        s.top = amt_bit & to_msb;
        s.mid = ~amt_bit;
        s.bot = amt_bit & ~to_msb;
        return s;
    endfunction

endpackage

// File: rtl/mux3_onehot.sv
`timescale 1ns/1ps
module mux3_onehot
    import shift_net_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] top,
    input  logic [W-1:0] mid,
    input  logic [W-1:0] bot,
    input  mux_sel_t     sel,
    output logic [W-1:0] y
);
    always_comb begin
        y = ({W{sel.top}} & top) | ({W{sel.mid}} & mid) | ({W{sel.bot}} & bot);
    end
endmodule

// File: rtl/shift_stage.sv
`timescale 1ns/1ps
module shift_stage
    import shift_net_pkg::*;
#(
    parameter int W    = 8,
    parameter int DIST = 1
) (
    input  logic [W-1:0] x,
    input  mux_sel_t     sel,
    input  fill_mode_e   mode,
    output logic [W-1:0] y
);
    logic [W-1:0]    moved_up;
    logic [W-1:0]    moved_down;
    logic [DIST-1:0] low_fill;
    logic [DIST-1:0] high_fill;

    always_comb begin
        // vacated low bits after a move toward the MSB
        low_fill = (mode == FILL_WRAP) ? x[W-1 -: DIST] : '0;
        // vacated high bits after a move toward the LSB
        unique case (mode)
            FILL_WRAP: high_fill = x[DIST-1:0];
            FILL_SIGN: high_fill = {DIST{x[W-1]}};
            default:   high_fill = '0;
        endcase
        moved_up   = {x[W-1-DIST:0], low_fill};
        moved_down = {high_fill, x[W-1:DIST]};
    end

    mux3_onehot #(.W(W)) u_mux (
        .top (moved_up),
        .mid (x),
        .bot (moved_down),
        .sel (sel),
        .y   (y)
    );
endmodule

// File: rtl/shift_net.sv
`timescale 1ns/1ps
module shift_net
    import shift_net_pkg::*;
#(
    parameter  int DATA_W = shift_net_pkg::DATA_W,
    localparam int AMT_W  = $clog2(DATA_W),
    localparam int SEL_W  = shift_net_pkg::SEL_W * AMT_W
) (
    input  logic [DATA_W-1:0] din,
    input  logic              dir,
    input  logic [AMT_W-1:0]  amount,
    input  logic [1:0]        mode,
    output logic [DATA_W-1:0] dout,
    output logic [SEL_W-1:0]  stage_sel
);
    fill_mode_e        fill;
    logic [DATA_W-1:0] chain [AMT_W+1];

    assign fill     = fill_mode_e'(mode);
    assign chain[0] = din;

    for (genvar g = 0; g < AMT_W; g++) begin : g_stage
        mux_sel_t s;
        assign s = stage_select(amount[g], dir);
        assign stage_sel[3*g +: 3] = s;

        shift_stage #(.W(DATA_W), .DIST(1 << g)) u_stage (
            .x    (chain[g]),
            .sel  (s),
            .mode (fill),
            .y    (chain[g+1])
        );
    end

    assign dout = chain[AMT_W];
endmodule

// File: rtl/shift_net_chk.sv
`timescale 1ns/1ps
module shift_net_chk #(
    parameter  int DATA_W = 8,
    localparam int AMT_W  = $clog2(DATA_W),
    localparam int SEL_W  = 3 * AMT_W
) (
    input logic [DATA_W-1:0] din,
    input logic              dir,
    input logic [AMT_W-1:0]  amount,
    input logic [1:0]        mode,
    input logic [DATA_W-1:0] dout,
    input logic [SEL_W-1:0]  stage_sel
);
    logic [DATA_W-1:0] low_mask;
    logic [DATA_W-1:0] high_mask;

    always_comb begin
        low_mask  = ~({DATA_W{1'b1}} << amount);
        high_mask = ~({DATA_W{1'b1}} >> amount);

        if (amount == '0)
            p_identity_r1: assert (dout == din);
        if (dir && mode != 2'b10)
            p_left_zero_fill_r2: assert ((dout & low_mask) == '0);
        if (!dir && (mode == 2'b00 || mode == 2'b11))
            p_right_zero_fill_r3: assert ((dout & high_mask) == '0);
        if (!dir && mode == 2'b01 && amount != '0)
            p_right_sign_keep_r4: assert (dout[DATA_W-1] == din[DATA_W-1]);
        if (mode == 2'b10)
            p_rotate_keeps_ones_r5: assert ($countones(dout) == $countones(din));

        for (int g = 0; g < AMT_W; g++) begin
            p_sel_onehot_r8: assert ($countones(stage_sel[3*g +: 3]) == 1);
            p_sel_pass_r8:   assert (stage_sel[3*g+1] == !amount[g]);
        end
    end
endmodule

bind shift_net shift_net_chk #(.DATA_W(DATA_W)) u_shift_net_chk (
    .din       (din),
    .dir       (dir),
    .amount    (amount),
    .mode      (mode),
    .dout      (dout),
    .stage_sel (stage_sel)
);

// File: tb/shift_net_bench.sv
`timescale 1ns/1ps
module shift_net_bench;

    localparam int W = 8;

    typedef struct packed {
        logic [7:0] din;
        logic       dir;
        logic [2:0] amt;
        logic [1:0] mode;
        logic [7:0] exp;
    } vec_t;

    // hand-computed corner vectors
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'h96, 1'b1, 3'd0, 2'b00, 8'h96},   // R1
        '{8'h96, 1'b1, 3'd2, 2'b00, 8'h58},   // R2
        '{8'h96, 1'b0, 3'd3, 2'b00, 8'h12},   // R3
        '{8'h96, 1'b0, 3'd3, 2'b01, 8'hF2},   // R4
        '{8'h96, 1'b1, 3'd3, 2'b10, 8'hB4},   // R5
        '{8'h96, 1'b0, 3'd1, 2'b10, 8'h4B},   // R5
        '{8'h96, 1'b1, 3'd4, 2'b10, 8'h69},   // R6
        '{8'h96, 1'b0, 3'd4, 2'b10, 8'h69},   // R6
        '{8'h96, 1'b0, 3'd2, 2'b11, 8'h25},   // R7
        '{8'h80, 1'b0, 3'd7, 2'b01, 8'hFF},   // R4
        '{8'h7F, 1'b0, 3'd7, 2'b01, 8'h00},   // R4
        '{8'h01, 1'b1, 3'd7, 2'b01, 8'h80},   // R2
        '{8'hFF, 1'b1, 3'd7, 2'b10, 8'hFF}    // R5
    };
    localparam string VTAG [NV] = '{"R1","R2","R3","R4","R5","R5","R6","R6",
                                    "R7","R4","R4","R2","R5"};

    logic       clk = 1'b0;
    logic [7:0] din = '0;
    logic       dir = 1'b0;
    logic [2:0] amount = '0;
    logic [1:0] mode = '0;
    logic [7:0] dout;
    logic [8:0] stage_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    shift_net u_shift_net (
        .din       (din),
        .dir       (dir),
        .amount    (amount),
        .mode      (mode),
        .dout      (dout),
        .stage_sel (stage_sel)
    );

    function automatic logic [7:0] ref_shift(input logic [7:0] d, input logic left,
                                             input logic [2:0] k, input logic [1:0] m);
        logic [15:0] twice;
        logic [15:0] wrapped;
        logic signed [7:0] sd;
        twice = {d, d};
        sd    = d;
        if (m == 2'b10) begin
            if (left) begin
                wrapped = twice << k;
                return wrapped[15:8];
            end
            wrapped = twice >> k;
            return wrapped[7:0];
        end
        if (left)      return d << k;
        if (m == 2'b01) return 8'(sd >>> k);
        return d >> k;
    endfunction

    function automatic logic [8:0] ref_sel(input logic left, input logic [2:0] k);
        logic [8:0] s;
        for (int g = 0; g < 3; g++)
            s[3*g +: 3] = {k[g] & left, ~k[g], k[g] & ~left};
        return s;
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s din=%h dir=%0d amt=%0d mode=%0d actual=%h expected=%h",
                     tag, din, dir, amount, mode, act, exp);
        end
    endtask

    task automatic check_sel(input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R8 dir=%0d amt=%0d actual=%b expected=%b", dir, amount, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] d, input logic l, input logic [2:0] k,
                         input logic [1:0] m);
        @(negedge clk);
        din = d; dir = l; amount = k; mode = m;
        #1;   // same cycle, before the next rising edge (R9)
    endtask

    initial begin
        // initial state: all inputs zero -> output zero, pass selects
        #1;
        check8("R1", dout, 8'h00);
        check_sel(stage_sel, 9'b010_010_010);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].din, VECS[i].dir, VECS[i].amt, VECS[i].mode);
            check8(VTAG[i], dout, VECS[i].exp);
        end

        // R9: change inputs mid-cycle, result visible before any edge
        @(posedge clk);
        #0.5;
        din = 8'hC3; dir = 1'b1; amount = 3'd1; mode = 2'b00;
        #0.5;
        check8("R9", dout, 8'h86);

        // exhaustive sweep against the reference model
        for (int m = 0; m < 4; m++)
            for (int l = 0; l < 2; l++)
                for (int k = 0; k < 8; k++)
                    for (int d = 0; d < 256; d++) begin
                        string tag;
                        apply(8'(d), 1'(l), 3'(k), 2'(m));
                        if (k == 0)       tag = "R1";
                        else if (m == 2)  tag = (k == 4) ? "R6" : "R5";
                        else if (l == 1)  tag = "R2";
                        else if (m == 1)  tag = "R4";
                        else if (m == 3)  tag = "R7";
                        else              tag = "R3";
                        check8(tag, dout, ref_shift(8'(d), 1'(l), 3'(k), 2'(m)));
                        check_sel(stage_sel, ref_sel(1'(l), 3'(k)));
                    end

        // R6: rotate by 4 equal in both directions for a sample of words
        for (int d = 0; d < 256; d += 17) begin
            logic [7:0] up;
            apply(8'(d), 1'b1, 3'd4, 2'b10);
            up = dout;
            apply(8'(d), 1'b0, 3'd4, 2'b10);
            check8("R6", dout, up);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule